// File: doc/BRIEF.md
# Windowed Watchdog Fault Detector

This block supervises a service line toggled by a processor and reports a fault when the processor's service activity falls outside an allowed time window. Only high-to-low transitions of the service line count as service events. Each accepted event restarts a window timer. An event that comes before the lower window limit is a fast fault. If no event arrives before the upper limit is reached, the result is a slow fault. The fault is reported as a single-cycle pulse together with a two-bit code that tells the two kinds apart. A surrounding reset generator would use this pulse to start a reset sequence.

The service line is asynchronous to the block clock and passes through a synchronizer first. A separate active-high input from the reset generator marks the interval during which a system reset is being driven. While that input is high, the timer is held at zero and service events are ignored. When it falls, the timer starts counting again. The first service event after that release only arms the window and is never treated as too early. After a fault, the detector stays silent until the reset-active input has gone high and then low again.

A 3-bit select chooses one of eight window pairs. The pairs are defined in tenths of a millisecond and scaled by a ticks-per-tenth-millisecond parameter. The watchdog has no enable and cannot be switched off. The clock must be fast enough that a service low pulse of 200 ns spans at least two clock periods.

Top module: `wwd_fault_detect`

## Requirements
- R1: While `rst_n` is low, `fault_pulse` is 0 and `fault_code` is 2'b00.
- R2: Only a falling edge of `svc_in` restarts the window timer; a rising edge leaves the timer running. A falling edge is consumed on the third rising clock edge after the input changes (two synchronizer flops plus one edge-detect flop).
- R3: When an accepted falling edge comes fewer than F clock cycles after the previous accepted one, a fast fault is raised. `fault_code` = 2'b01 is registered on the same clock edge that consumes the falling edge.
- R4: A falling edge that comes at least F and at most S-1 cycles after the previous one raises no fault and restarts the window.
- R5: A slow fault is raised when S clock edges pass with no accepted falling edge, counted from the previous accepted edge or from the first edge after release. `fault_code` = 2'b10 is registered on that S-th edge.
- R6: While `sup_rst` is high, no fault is raised, falling edges are ignored and the timer is held at zero. Counting resumes from zero on the first clock edge on which `sup_rst` is sampled low.
- R7: The first accepted falling edge after `sup_rst` falls never raises a fast fault.
- R8: `fault_pulse` is high for exactly one cycle per fault and equals the OR of the bits of `fault_code`. After a fault, no further fault is raised until `sup_rst` has been high and then low again.
- R9: `win_sel` picks the pair (F, S) in tenths of a millisecond, times TICKS_PER_TENTH_MS: 0: (15, 100), 1: (150, 1000), 2: (150, 3000), 3: (150, 100000), 4: (150, 600000), 5: (240, 440), 6: (410, 760), 7: (7680, 12400).
- R10: The window timer saturates at S-1 and never wraps around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| sup_rst | input | 1 | High while the reset generator drives a system reset |
| svc_in | input | 1 | Asynchronous service line from the processor |
| win_sel | input | 3 | Window pair select |
| fault_pulse | output | 1 | One-cycle fault indication |
| fault_code | output | 2 | 2'b01 fast fault, 2'b10 slow fault, 2'b00 otherwise |

## Verification
On every cycle, the assertions check the following: the fault code is one-hot or zero; a fault lasts a single cycle; no fault and a zeroed timer follow any cycle with `sup_rst` high; a fast fault always follows a consumed falling edge and never the first edge after release; a slow fault always follows a timer at its limit; and the timer holds once saturated. Only the bench scenarios can show the cycle-exact placement of faults relative to the service edges. They also show the inclusive and exclusive ends of both window limits, that rising edges and edges during reset leave the timing unchanged, and that the select really changes both limits.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_FAST = 2'b01,
    FLT_SLOW = 2'b10
  } fault_code_e;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_FIRST = 2'd1,
    ST_RUN   = 2'd2,
    ST_TRIP  = 2'd3
  } wd_state_e;

  localparam int unsigned NUM_WINDOWS = 8;
  localparam longint unsigned SLOW_MAX_TENTHS = 64'd600000;

  // lower window limit in tenths of a millisecond
  function automatic longint unsigned fast_tenths(input int sel);
    case (sel)
      0:       return 64'd15;
      5:       return 64'd240;
      6:       return 64'd410;
      7:       return 64'd7680;
      default: return 64'd150;
    endcase
  endfunction

  // upper window limit in tenths of a millisecond
  function automatic longint unsigned slow_tenths(input int sel);
    case (sel)
      0:       return 64'd100;
      1:       return 64'd1000;
      2:       return 64'd3000;
      3:       return 64'd100000;
      4:       return SLOW_MAX_TENTHS;
      5:       return 64'd440;
      6:       return 64'd760;
      default: return 64'd12400;
    endcase
  endfunction

endpackage

// File: rtl/wwd_edge_sync.sv
module wwd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall_o
);

  localparam int unsigned PW = STAGES + 1;

  // pipe_q[STAGES-1] is the synchronized level, pipe_q[STAGES] its previous value
  logic [PW-1:0] pipe_q;
  logic [PW-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[PW-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  assign fall_o = pipe_q[STAGES] & ~pipe_q[STAGES-1];

endmodule

// File: rtl/wwd_window_timer.sv
module wwd_window_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [CW-1:0] lim_m1_i,
  output logic [CW-1:0] cnt_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i || (cnt_q < lim_m1_i);
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R10: once the limit is reached the count stays put until cleared
  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && (cnt_q >= lim_m1_i) && $stable(lim_m1_i)) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/wwd_judge.sv
module wwd_judge
  import wwd_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sup_rst_i,
  input  logic          fall_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] fast_m1_i,
  input  logic [CW-1:0] slow_m1_i,
  output logic          clr_o,
  output logic [1:0]    code_o
);

  wd_state_e   st_q, st_d;
  fault_code_e code_q, code_d;
  logic        late;

  assign late = (cnt_i >= slow_m1_i);

  always_comb begin
    st_d   = st_q;
    code_d = FLT_NONE;
    if (sup_rst_i) begin
      st_d = ST_HOLD;
    end else begin
      unique case (st_q)
        ST_HOLD:  st_d = ST_FIRST;
        ST_FIRST: begin
          if (late) begin
            st_d   = ST_TRIP;
            code_d = FLT_SLOW;
          end else if (fall_i) begin
            st_d = ST_RUN;
          end
        end
        ST_RUN: begin
          if (late) begin
            st_d   = ST_TRIP;
            code_d = FLT_SLOW;
          end else if (fall_i && (cnt_i < fast_m1_i)) begin
            st_d   = ST_TRIP;
            code_d = FLT_FAST;
          end
        end
        default:  st_d = ST_TRIP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HOLD;
      code_q <= FLT_NONE;
    end else begin
      st_q   <= st_d;
      code_q <= code_d;
    end
  end

  assign clr_o  = sup_rst_i || fall_i || (st_q == ST_HOLD) || (st_q == ST_TRIP);
  assign code_o = code_q;

  a_r8_code_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(code_o));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o != 2'b00) |=> (code_o == 2'b00));

  a_r6_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    sup_rst_i |=> (code_o == 2'b00));

  a_r3_fast_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == 2'b01) |-> $past(fall_i));

  a_r7_first_not_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FIRST && fall_i) |=> (code_o != 2'b01));

  a_r5_slow_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == 2'b10) |-> $past(cnt_i >= slow_m1_i));

endmodule

// File: rtl/wwd_fault_detect.sv
module wwd_fault_detect
  import wwd_pkg::*;
#(
  parameter int unsigned TICKS_PER_TENTH_MS = 25000,
  parameter int unsigned SYNC_STAGES        = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_rst,
  input  logic       svc_in,
  input  logic [2:0] win_sel,
  output logic       fault_pulse,
  output logic [1:0] fault_code
);

  localparam longint unsigned MAX_TICKS = SLOW_MAX_TENTHS * TICKS_PER_TENTH_MS;
  localparam int unsigned     CW        = $clog2(MAX_TICKS + 1);

  logic [CW-1:0] fast_tab [NUM_WINDOWS];
  logic [CW-1:0] slow_tab [NUM_WINDOWS];

  for (genvar g = 0; g < NUM_WINDOWS; g++) begin : g_win
    assign fast_tab[g] = CW'(fast_tenths(g) * TICKS_PER_TENTH_MS - 64'd1);
    assign slow_tab[g] = CW'(slow_tenths(g) * TICKS_PER_TENTH_MS - 64'd1);
  end

  logic          fall;
  logic          clr;
  logic [CW-1:0] cnt;
  logic [CW-1:0] fast_m1;
  logic [CW-1:0] slow_m1;

  assign fast_m1 = fast_tab[win_sel];
  assign slow_m1 = slow_tab[win_sel];

  wwd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (svc_in),
    .fall_o (fall)
  );

  wwd_window_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr),
    .lim_m1_i (slow_m1),
    .cnt_o    (cnt)
  );

  wwd_judge #(.CW(CW)) u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sup_rst_i (sup_rst),
    .fall_i    (fall),
    .cnt_i     (cnt),
    .fast_m1_i (fast_m1),
    .slow_m1_i (slow_m1),
    .clr_o     (clr),
    .code_o    (fault_code)
  );

  assign fault_pulse = |fault_code;

  a_r6_timer_held: assert property (@(posedge clk) disable iff (!rst_n)
    sup_rst |=> (cnt == '0));

  a_r10_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(win_sel) |=> (cnt <= slow_m1));

endmodule

// File: tb/wwd_fault_detect_test.sv
module wwd_fault_detect_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sup_rst;
  logic       svc_in;
  logic [2:0] win_sel;
  logic       fault_pulse;
  logic [1:0] fault_code;

  wwd_fault_detect #(.TICKS_PER_TENTH_MS(1), .SYNC_STAGES(2)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sup_rst     (sup_rst),
    .svc_in      (svc_in),
    .win_sel     (win_sel),
    .fault_pulse (fault_pulse),
    .fault_code  (fault_code)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  int nflt = 0;
  int last_cyc = -1;
  logic [1:0] last_code = 2'b00;
  int runs = 0;
  int fails = 0;
  int rel = 0;
  int last_fall = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && fault_pulse) begin
      nflt      = nflt + 1;
      last_cyc  = cyc;
      last_code = fault_code;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic release_sup();
    @(negedge clk);
    sup_rst = 1'b1;
    svc_in  = 1'b1;
    repeat (4) @(negedge clk);
    sup_rst = 1'b0;
    rel     = cyc;
  endtask

  task automatic fall_now();
    svc_in    = 1'b0;
    last_fall = cyc;
    repeat (2) @(negedge clk);
    svc_in = 1'b1;
  endtask

  task automatic fall_after(input int d);
    while (cyc < last_fall + d) @(negedge clk);
    fall_now();
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // R1
  task automatic t_reset();
    rst_n = 1'b0; sup_rst = 1'b1; svc_in = 1'b1; win_sel = 3'd0;
    repeat (3) @(negedge clk);
    check(fault_pulse == 1'b0 && fault_code == 2'b00, "R1 reset outputs", int'(fault_code), 0);
    rst_n = 1'b1;
  endtask

  // R5 R6: no service after release gives slow fault at rel+1+S
  task automatic t_slow_from_release();
    int base;
    release_sup();
    base = nflt;
    wait_until(rel + 1 + 100 + 3);
    check(nflt - base == 1, "R5 one slow fault", nflt - base, 1);
    check(last_code == 2'b10, "R5 slow code", int'(last_code), 2);
    check(last_cyc == rel + 101, "R5 slow fault cycle", last_cyc, rel + 101);
  endtask

  // R4 R7 R2: legal spacing including both window ends, then slow
  task automatic t_normal();
    int base;
    release_sup();
    base = nflt;
    wait_until(rel + 2);
    fall_now();            // R7 first edge right after release
    fall_after(20);
    fall_after(15);        // R4 lower end inclusive
    fall_after(99);        // R4 upper end S-1
    fall_after(40);
    check(nflt - base == 0, "R4 R7 no fault in window", nflt - base, 0);
    wait_until(last_fall + 3 + 100 + 3);
    check(nflt - base == 1 && last_code == 2'b10, "R2 slow after last edge", int'(last_code), 2);
    check(last_cyc == last_fall + 103, "R2 restart point", last_cyc, last_fall + 103);
  endtask

  // R3: spacing one below lower limit
  task automatic t_fast();
    int base;
    release_sup();
    base = nflt;
    wait_until(rel + 3);
    fall_now();
    fall_after(14);
    wait_until(last_fall + 6);
    check(nflt - base == 1 && last_code == 2'b01, "R3 fast code", int'(last_code), 1);
    check(last_cyc == last_fall + 3, "R3 fast fault cycle", last_cyc, last_fall + 3);
    // R8 R10: silence afterwards despite service and long idle
    fall_after(5);
    fall_after(20);
    wait_until(cyc + 400);
    check(nflt - base == 1, "R8 R10 no further fault", nflt - base, 1);
  endtask

  // R2: rising edge mid-window does not restart
  task automatic t_rising_ignored();
    int base;
    int f;
    release_sup();
    base = nflt;
    wait_until(rel + 2);
    svc_in = 1'b0;
    f = cyc;
    wait_until(f + 60);
    svc_in = 1'b1;
    wait_until(f + 3 + 100 + 3);
    check(nflt - base == 1 && last_cyc == f + 103, "R2 rising edge ignored", last_cyc, f + 103);
  endtask

  // R6: reset mid-window clears timer, edges during reset ignored
  task automatic t_reset_hold();
    int base;
    release_sup();
    wait_until(rel + 2);
    fall_now();
    wait_until(last_fall + 80);
    base = nflt;
    sup_rst = 1'b1;
    for (int i = 0; i < 40; i++) begin
      svc_in = 1'b0;
      repeat (2) @(negedge clk);
      svc_in = 1'b1;
      repeat (3) @(negedge clk);
    end
    check(nflt - base == 0, "R6 no fault during reset", nflt - base, 0);
    repeat (4) @(negedge clk);
    sup_rst = 1'b0;
    rel = cyc;
    wait_until(rel + 99);
    check(nflt - base == 0, "R6 timer restarted from zero", nflt - base, 0);
    wait_until(rel + 104);
    check(nflt - base == 1 && last_cyc == rel + 101, "R6 slow from release", last_cyc, rel + 101);
  endtask

  // R9: option 6 (F=410,S=760) and option 1 (S=1000)
  task automatic t_select();
    int base;
    win_sel = 3'd6;
    release_sup();
    base = nflt;
    wait_until(rel + 2);
    fall_now();
    fall_after(410);
    fall_after(409);
    wait_until(last_fall + 6);
    check(nflt - base == 1 && last_code == 2'b01 && last_cyc == last_fall + 3,
          "R9 option6 fast limit", last_cyc, last_fall + 3);
    win_sel = 3'd6;
    release_sup();
    base = nflt;
    wait_until(rel + 2);
    fall_now();
    wait_until(last_fall + 3 + 760 + 3);
    check(nflt - base == 1 && last_code == 2'b10 && last_cyc == last_fall + 763,
          "R9 option6 slow limit", last_cyc, last_fall + 763);
    win_sel = 3'd1;
    release_sup();
    base = nflt;
    wait_until(rel + 1 + 1000 + 3);
    check(nflt - base == 1 && last_cyc == rel + 1001, "R9 option1 slow limit", last_cyc, rel + 1001);
    win_sel = 3'd0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  endtask

  initial begin
    t_reset();
    t_slow_from_release();
    t_normal();
    t_fast();
    t_rising_ignored();
    t_reset_hold();
    t_select();
    finish_run();
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      runs++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

endmodule